// File: doc/BRIEF.md
# Receive Destination Address Filter with Multicast Hash

This block sits on the receive side of an Ethernet MAC and decides, from the 48-bit destination address alone, whether the frame is to be kept. The destination bytes are presented one at a time. A start strobe marks the first byte, and idle cycles between bytes are allowed. While the bytes arrive, the block assembles the address and runs a CRC-32 over it, eight bits per cycle. One cycle after the sixth byte it produces a one-cycle decision pulse, an accept flag, and three classification flags for the receive status word.

Four acceptance conditions can be enabled independently through a 4-bit mode input:

- **Promiscuous:** every frame is accepted.
- **Own address:** the destination equals the station address.
- **Broadcast:** the destination is all ones.
- **Hashed multicast:** the top six bits of the CRC select one bit of a 64-bit table, and that bit is set.

The table arrives as two 32-bit words. A swap input selects the alternative register layout used by some bus variants.

Top module: `mcast_addr_filter`

## Requirements
- R1: While `rstN` is low, and after reset until the first decision, `decideValid`, `acceptOut`, `isBcast`, `isPhysMatch` and `isHashHit` are all 0.
- R2: The hash index is bits [31:26] of a CRC-32 with polynomial 0x04C11DB7. The CRC starts at all ones. The six address bytes are fed in arrival order, each least significant bit first. The index selects bit `index` of the 64-bit table.
- R3: With `swapMode` = 0, table bits 31..0 are `hashWordLo[31:0]` and table bits 63..32 are `hashWordHi[31:0]`.
- R4: With `swapMode` = 1, table bits 63..32 are the byte-reversed `hashWordLo` and table bits 31..0 are the byte-reversed `hashWordHi`.
- R5: A destination is multicast when bit 0 of its first byte is 1. `isHashHit` is 1 only for a multicast destination that is not broadcast and whose indexed table bit is 1.
- R6: `isBcast` is 1 exactly when all 48 destination bits are 1.
- R7: `isPhysMatch` is 1 exactly when the destination equals `stationAddr`. The first received byte is compared with `stationAddr[7:0]` and the sixth with `stationAddr[47:40]`.
- R8: `cfgMode` bit 1 enables own-address acceptance, bit 2 enables hash-multicast acceptance and bit 3 enables broadcast acceptance. `acceptOut` is the OR of each enabled condition. The mode and table are sampled in the same cycle as the sixth byte.
- R9: When `cfgMode` bit 0 is 1, `acceptOut` is 1 whatever the address, table and other mode bits.
- R10: `decideValid` pulses for exactly one cycle, in the cycle after the sixth byte is taken. Between pulses, all flags hold their last values.
- R11: A byte taken with `startStb` restarts the address at byte 0, even in the middle of an address. Cycles with `byteValid` low are skipped. Bytes arriving after the sixth and before the next start are ignored and produce no decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startStb | input | 1 | Marks the current byte as destination byte 0 |
| byteValid | input | 1 | A destination byte is present on `byteData` |
| byteData | input | 8 | Destination address byte |
| cfgMode | input | 4 | bit0 promiscuous, bit1 own address, bit2 hash multicast, bit3 broadcast |
| swapMode | input | 1 | Selects the byte-reversed, word-swapped table layout |
| stationAddr | input | 48 | Station address, first byte in bits 7:0 |
| hashWordLo | input | 32 | Table word at offset 0 |
| hashWordHi | input | 32 | Table word at offset 4 |
| decideValid | output | 1 | One-cycle pulse marking a new decision |
| acceptOut | output | 1 | Frame accepted |
| isBcast | output | 1 | Destination was broadcast |
| isPhysMatch | output | 1 | Destination equalled the station address |
| isHashHit | output | 1 | Multicast destination hit a set table bit |

## Verification
The properties assume that the mode, table and station inputs are steady in the cycle the sixth byte is taken. They also assume that at least one byte cycle separates two decisions. The bench changes these inputs only between frames, on the falling edge, and never sends a frame of fewer than six taken bytes without a restart. Restarted addresses, idle gaps, stray bytes after a complete address, and layout changes are all produced inside these limits. The bench model sees exactly the inputs the design sampled on the same edge.

// File: rtl/addr_filt_pkg.sv
package addr_filt_pkg;
  localparam int ADDR_BYTES = 6;
  localparam int ADDR_W     = 8 * ADDR_BYTES;
  localparam int IDX_W      = $clog2(ADDR_BYTES);
  localparam int CNT_W      = $clog2(ADDR_BYTES + 1);
  localparam int CRC_W      = 32;

  // Strobes from control to datapath
  typedef struct packed {
    logic             take;   // byte accepted this cycle
    logic             first;  // byte is byte 0: restart CRC
    logic             last;   // byte completes the address
    logic [IDX_W-1:0] idx;    // byte position
  } filt_strobe_t;

  // One CRC bit step, reflected input, polynomial given without its low term
  function automatic logic [CRC_W-1:0] crcBit(input logic [CRC_W-1:0] c,
                                              input logic d,
                                              input logic [CRC_W-1:0] polyNoLsb);
    logic fb;
    logic [CRC_W-1:0] n;
    fb = c[CRC_W-1] ^ d;
    n  = {c[CRC_W-2:0], 1'b0};
    if (fb) n = (n ^ polyNoLsb) | {{(CRC_W-1){1'b0}}, 1'b1};
    return n;
  endfunction
endpackage

// File: rtl/addr_filt_ctrl.sv
module addr_filt_ctrl
  import addr_filt_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         startStb,
  input  logic         byteValid,
  output filt_strobe_t strb
);
  logic [CNT_W-1:0] byteCnt;  // bytes taken so far; ADDR_BYTES means idle
  logic             inFrame;
  logic [IDX_W-1:0] curIdx;
  logic             takeNow;

  assign inFrame = (byteCnt != CNT_W'(ADDR_BYTES));
  assign curIdx  = startStb ? '0 : byteCnt[IDX_W-1:0];
  assign takeNow = byteValid & (startStb | inFrame);

  always_comb begin
    strb.take  = takeNow;
    strb.first = byteValid & startStb;
    strb.idx   = curIdx;
    strb.last  = takeNow && (curIdx == IDX_W'(ADDR_BYTES - 1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) byteCnt <= CNT_W'(ADDR_BYTES);
    else if (takeNow) byteCnt <= CNT_W'(curIdx) + CNT_W'(1);
  end
endmodule

// File: rtl/addr_filt_dpath.sv
module addr_filt_dpath
  import addr_filt_pkg::*;
#(
  parameter int             WORD_W   = 32,
  parameter logic [CRC_W-1:0] POLY_NL = 32'h04C11DB6
)(
  input  logic              clk,
  input  logic              rstN,
  input  filt_strobe_t      strb,
  input  logic [7:0]        byteData,
  input  logic [3:0]        cfgMode,
  input  logic              swapMode,
  input  logic [ADDR_W-1:0] stationAddr,
  input  logic [WORD_W-1:0] hashWordLo,
  input  logic [WORD_W-1:0] hashWordHi,
  output logic              decideValid,
  output logic              acceptOut,
  output logic              isBcast,
  output logic              isPhysMatch,
  output logic              isHashHit
);
  localparam int TBL_W  = 2 * WORD_W;
  localparam int HIDX_W = $clog2(TBL_W);
  localparam int NBW    = WORD_W / 8;

  logic [CRC_W-1:0]  crcReg, crcNext;
  logic [ADDR_W-1:0] addrReg, addrFull;
  logic [WORD_W-1:0] loSw, hiSw;
  logic [TBL_W-1:0]  hashTable;
  logic [HIDX_W-1:0] hashIdx;
  logic              bcNow, physNow, mcNow, hitNow, accNow;

  // Byte reversal of both table words
  for (genvar b = 0; b < NBW; b++) begin : g_swab
    assign loSw[8*b +: 8] = hashWordLo[8*(NBW-1-b) +: 8];
    assign hiSw[8*b +: 8] = hashWordHi[8*(NBW-1-b) +: 8];
  end
  assign hashTable = swapMode ? {loSw, hiSw} : {hashWordHi, hashWordLo};

  // Current byte merged into the captured address
  for (genvar k = 0; k < ADDR_BYTES; k++) begin : g_addr
    assign addrFull[8*k +: 8] = (strb.idx == IDX_W'(k)) ? byteData : addrReg[8*k +: 8];
  end

  // Eight CRC steps per byte, LSB first
  always_comb begin
    logic [CRC_W-1:0] c;
    c = strb.first ? '1 : crcReg;
    for (int i = 0; i < 8; i++) c = crcBit(c, byteData[i], POLY_NL);
    crcNext = c;
  end

  always_comb begin
    hashIdx = crcNext[CRC_W-1 -: HIDX_W];
    bcNow   = &addrFull;
    physNow = (addrFull == stationAddr);
    mcNow   = addrFull[0];
    hitNow  = mcNow & ~bcNow & hashTable[hashIdx];
    accNow  = cfgMode[0] | (cfgMode[1] & physNow) |
              (cfgMode[2] & hitNow) | (cfgMode[3] & bcNow);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      crcReg  <= '1;
      addrReg <= '0;
    end else if (strb.take) begin
      crcReg <= crcNext;
      addrReg[8*strb.idx +: 8] <= byteData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      decideValid <= 1'b0;
      acceptOut   <= 1'b0;
      isBcast     <= 1'b0;
      isPhysMatch <= 1'b0;
      isHashHit   <= 1'b0;
    end else begin
      decideValid <= strb.last;
      if (strb.last) begin
        acceptOut   <= accNow;
        isBcast     <= bcNow;
        isPhysMatch <= physNow;
        isHashHit   <= hitNow;
      end
    end
  end
endmodule

// File: rtl/mcast_addr_filter.sv
module mcast_addr_filter
  import addr_filt_pkg::*;
#(
  parameter int WORD_W = 32
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              startStb,
  input  logic              byteValid,
  input  logic [7:0]        byteData,
  input  logic [3:0]        cfgMode,
  input  logic              swapMode,
  input  logic [47:0]       stationAddr,
  input  logic [WORD_W-1:0] hashWordLo,
  input  logic [WORD_W-1:0] hashWordHi,
  output logic              decideValid,
  output logic              acceptOut,
  output logic              isBcast,
  output logic              isPhysMatch,
  output logic              isHashHit
);
  filt_strobe_t strb;

  addr_filt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startStb(startStb), .byteValid(byteValid), .strb(strb)
  );

  addr_filt_dpath #(.WORD_W(WORD_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .byteData(byteData), .cfgMode(cfgMode),
    .swapMode(swapMode), .stationAddr(stationAddr), .hashWordLo(hashWordLo),
    .hashWordHi(hashWordHi), .decideValid(decideValid), .acceptOut(acceptOut),
    .isBcast(isBcast), .isPhysMatch(isPhysMatch), .isHashHit(isHashHit)
  );
endmodule

// File: rtl/addr_filt_checker.sv
module addr_filt_checker (
  input logic       clk,
  input logic       rstN,
  input logic       byteValid,
  input logic [7:0] byteData,
  input logic [3:0] cfgMode,
  input logic       decideValid,
  input logic       acceptOut,
  input logic       isBcast,
  input logic       isPhysMatch,
  input logic       isHashHit
);
  p_pulse_after_byte_r10: assert property (@(posedge clk) disable iff (!rstN)
    decideValid |-> $past(byteValid));
  p_hold_flags_r10: assert property (@(posedge clk) disable iff (!rstN)
    !decideValid |-> ($stable(acceptOut) && $stable(isBcast) &&
                      $stable(isPhysMatch) && $stable(isHashHit)));
  p_accept_all_r9: assert property (@(posedge clk) disable iff (!rstN)
    (decideValid && $past(cfgMode[0])) |-> acceptOut);
  p_bcast_no_hash_r5: assert property (@(posedge clk) disable iff (!rstN)
    decideValid |-> !(isBcast && isHashHit));
  p_bcast_last_byte_r6: assert property (@(posedge clk) disable iff (!rstN)
    (decideValid && isBcast) |-> ($past(byteData) == 8'hFF));
  p_accept_cause_r8: assert property (@(posedge clk) disable iff (!rstN)
    (decideValid && acceptOut) |-> ($past(cfgMode[0]) ||
      ($past(cfgMode[1]) && isPhysMatch) || ($past(cfgMode[2]) && isHashHit) ||
      ($past(cfgMode[3]) && isBcast)));
  p_phys_accept_r7: assert property (@(posedge clk) disable iff (!rstN)
    (decideValid && isPhysMatch && $past(cfgMode[1])) |-> acceptOut);
endmodule

bind mcast_addr_filter addr_filt_checker u_chk (
  .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteData(byteData),
  .cfgMode(cfgMode), .decideValid(decideValid), .acceptOut(acceptOut),
  .isBcast(isBcast), .isPhysMatch(isPhysMatch), .isHashHit(isHashHit)
);

// File: tb/sim_mcast_addr_filter.sv
module sim_mcast_addr_filter;
  logic        clk = 0;
  logic        rstN = 0;
  logic        startStb = 0, byteValid = 0, swapMode = 0;
  logic [7:0]  byteData = 0;
  logic [3:0]  cfgMode = 0;
  logic [47:0] stationAddr = 48'h5544_3322_1100;
  logic [31:0] hashWordLo = 0, hashWordHi = 0;
  logic        decideValid, acceptOut, isBcast, isPhysMatch, isHashHit;

  logic [63:0] tbl = 0;   // logical hash table in the bench
  int checks = 0, fails = 0;
  bit started = 0;

  // model state
  logic [7:0] q[$];
  bit   open = 0;
  bit   eValid = 0, eAcc = 0, eBc = 0, ePh = 0, eHit = 0;

  always #5 clk = ~clk;

  mcast_addr_filter u0 (
    .clk(clk), .rstN(rstN), .startStb(startStb), .byteValid(byteValid),
    .byteData(byteData), .cfgMode(cfgMode), .swapMode(swapMode),
    .stationAddr(stationAddr), .hashWordLo(hashWordLo), .hashWordHi(hashWordHi),
    .decideValid(decideValid), .acceptOut(acceptOut), .isBcast(isBcast),
    .isPhysMatch(isPhysMatch), .isHashHit(isHashHit)
  );

  function automatic logic [31:0] bswap(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  // R2 reference: standard polynomial form, bytes LSB first
  function automatic int hashOf(input logic [47:0] a);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int k = 0; k < 6; k++)
      for (int i = 0; i < 8; i++) begin
        bit fb = c[31] ^ a[8*k + i];
        c = c << 1;
        if (fb) c = c ^ 32'h04C1_1DB7;
      end
    return int'(c >> 26);
  endfunction

  always @(posedge clk) begin
    started = 1;
    if (!rstN) begin
      q.delete(); open = 0; eValid = 0; eAcc = 0; eBc = 0; ePh = 0; eHit = 0;
    end else begin
      eValid = 0;
      if (startStb && byteValid) begin q.delete(); q.push_back(byteData); open = 1; end
      else if (byteValid && open) q.push_back(byteData);
      if (open && q.size() == 6) begin
        logic [47:0] a;
        bit mc;
        a = {q[5], q[4], q[3], q[2], q[1], q[0]};
        eBc = (a == 48'hFFFF_FFFF_FFFF);
        ePh = (a == stationAddr);
        mc  = q[0][0];
        eHit = mc && !eBc && tbl[hashOf(a)];
        eAcc = cfgMode[0] || (cfgMode[1] && ePh) || (cfgMode[2] && eHit) || (cfgMode[3] && eBc);
        eValid = 1; open = 0;
      end
    end
  end

  task automatic cmp(input string tag, input bit act, input bit exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %0b expected %0b", tag, $time, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) if (started) begin
    cmp(rstN ? "R10 decideValid" : "R1 decideValid", decideValid, eValid);
    cmp(rstN ? "R8/R9 acceptOut" : "R1 acceptOut", acceptOut, eAcc);
    cmp(rstN ? "R6 isBcast" : "R1 isBcast", isBcast, eBc);
    cmp(rstN ? "R7 isPhysMatch" : "R1 isPhysMatch", isPhysMatch, ePh);
    cmp(rstN ? "R2/R5 isHashHit" : "R1 isHashHit", isHashHit, eHit);
  end

  task automatic loadTable(input logic [63:0] t, input bit sw);
    @(negedge clk);
    tbl = t; swapMode = sw;
    if (!sw) begin hashWordLo = t[31:0]; hashWordHi = t[63:32]; end
    else begin hashWordLo = bswap(t[63:32]); hashWordHi = bswap(t[31:0]); end  // R4
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(negedge clk); byteValid = 0; startStb = 0; end
  endtask

  task automatic sendAddr(input logic [47:0] a, input int gapAt, input int nBytes = 6);
    for (int k = 0; k < nBytes; k++) begin
      if (k == gapAt) idle(2);  // R11 gap
      @(negedge clk);
      byteValid = 1; startStb = (k == 0); byteData = a[8*k +: 8];
    end
    idle(2);
  endtask

  function automatic logic [47:0] mcAddr();
    logic [47:0] a = {$urandom, $urandom};
    a[0] = 1'b1;
    return a;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R10 watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [47:0] a;
    repeat (3) @(negedge clk);   // R1 reset values compared each clock
    rstN = 1;
    idle(2);
    // R6 broadcast, enabled and disabled
    cfgMode = 4'b1000; sendAddr(48'hFFFF_FFFF_FFFF, -1);
    cfgMode = 4'b0000; sendAddr(48'hFFFF_FFFF_FFFF, -1);
    // R7 own address
    cfgMode = 4'b0010; sendAddr(stationAddr, 3);
    sendAddr(stationAddr ^ 48'h0100_0000_0000, -1);
    // R2 R3 hash hit with single bit set, normal layout
    cfgMode = 4'b0100;
    for (int i = 0; i < 8; i++) begin
      a = mcAddr();
      loadTable(64'd1 << hashOf(a), 0); sendAddr(a, -1);
      loadTable(~(64'd1 << hashOf(a)), 0); sendAddr(a, -1);
    end
    // R4 swapped layout
    for (int i = 0; i < 8; i++) begin
      a = mcAddr();
      loadTable(64'd1 << hashOf(a), 1); sendAddr(a, 2);
      loadTable(~(64'd1 << hashOf(a)), 1); sendAddr(a, -1);
    end
    // R5 broadcast and unicast never hash hit
    loadTable('1, 0); cfgMode = 4'b0100;
    sendAddr(48'hFFFF_FFFF_FFFF, -1);
    sendAddr(48'h0000_1234_5600, -1);
    // R9 accept-all overrides
    cfgMode = 4'b0001; loadTable('0, 0); sendAddr(48'h0A0B_0C0D_0E10, -1);
    // R11 restart mid-address, then stray bytes
    cfgMode = 4'b0010;
    sendAddr(48'hFFFF_FFFF_FFFF, -1, 3);
    sendAddr(stationAddr, -1);
    for (int i = 0; i < 5; i++) begin @(negedge clk); byteValid = 1; startStb = 0; byteData = 8'hFF; end
    idle(3);
    // random mix
    for (int n = 0; n < 300; n++) begin
      int kind = $urandom % 4;
      cfgMode = 4'($urandom);
      loadTable({$urandom, $urandom}, 1'($urandom));
      case (kind)
        0: a = 48'hFFFF_FFFF_FFFF;
        1: a = stationAddr;
        2: a = mcAddr();
        default: a = {$urandom, $urandom};
      endcase
      sendAddr(a, int'($urandom % 8));
    end
    idle(3);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule